// File: doc/BRIEF.md
# Panel Reset and Lockout Sequencer

This block sits on the host side of a display link. It produces the active-low reset pulse for the panel and then holds back host commands until the panel can accept them. When `startReq` is seen, the reset line goes low for a fixed number of cycles and is then released. A general lockout follows, and during it no command is granted. If the panel reported itself awake at the moment the reset began, a second and longer lockout follows. During that second lockout only the wake command is held back. Every other command passes.

All durations are given as clock-cycle parameters. By default they are derived from `CLK_HZ`: 10 µs of reset, 5 ms of general lockout, and 120 ms from release to the wake command. A bench can override them with small values. The host keeps `cmdReq` high and tags the wake command with `cmdIsWake`. `cmdGrant` tells it in the same cycle whether the command may go out.

Top module: `panel_reset_seq`

## Requirements
- R1: After the system reset `rstN` and before any start request, `panelResetN` is 1, `busy` is 0 and `cmdGrant` is 0 whatever `cmdReq` shows.
- R2: A start request sampled at a clock edge drives `panelResetN` to 0 and `busy` to 1 from that edge. The reset stays low for exactly `PULSE_CYC` cycles and is never shortened.
- R3: For `SHORT_CYC` cycles after `panelResetN` returns to 1, `cmdGrant` stays 0 for every command.
- R4: Once the general lockout is over, a command with `cmdIsWake` = 0 is granted whether the panel was awake or asleep at the start.
- R5: If `panelAwake` was 1 at the start edge, a command with `cmdIsWake` = 1 is refused until `LONG_CYC` cycles after the release.
- R6: If `panelAwake` was 0 at the start edge, the wake command is granted as soon as the general lockout ends.
- R7: `panelAwake` is sampled only at the start edge. Later changes do not alter the lockouts of that sequence.
- R8: A start request during a running sequence restarts it. The reset goes low again for a full `PULSE_CYC` cycles and `panelAwake` is sampled anew.
- R9: `busy` stays 1 until the last applicable lockout ends: `PULSE_CYC+LONG_CYC` cycles after the start if the panel was awake, `PULSE_CYC+SHORT_CYC` cycles if it was asleep. It then drops to 0.
- R10: `cmdGrant` is never 1 while `cmdReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | System reset, active low |
| startReq | input | 1 | Request to begin (or restart) a reset sequence |
| panelAwake | input | 1 | Panel is out of sleep; sampled at the start edge |
| cmdReq | input | 1 | Host wants to send a command this cycle |
| cmdIsWake | input | 1 | The requested command is the wake command |
| panelResetN | output | 1 | Reset line to the panel, active low, registered |
| cmdGrant | output | 1 | Command may be sent this cycle |
| busy | output | 1 | A reset sequence or one of its lockouts is in progress |

## Verification
Take the edge that samples `startReq` as cycle 0. `panelResetN` falls and `busy` rises at cycle 0. The reset returns high at cycle `PULSE_CYC`. A granted command appears at `PULSE_CYC+SHORT_CYC`, or at `PULSE_CYC+LONG_CYC` for the wake command after an awake start. Because `cmdGrant` is combinational from the state, it changes at those same edges. For each sequence, the bench's driver computes the full expected trace of these three outputs from the cycle-0 count and queues it. The monitor compares each entry in the falling-edge half of its own cycle, so every sample lands one half-period after the register update it depends on.

// File: rtl/panel_rst_pkg.sv
package panel_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_WAIT_SHORT,
    ST_WAIT_LONG,
    ST_READY
  } seqState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic loadPulse;
    logic loadShort;
    logic loadLong;
    logic captureAwake;
  } seqStrobe_t;

endpackage

// File: rtl/panel_rst_timer.sv
module panel_rst_timer
  import panel_rst_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       panelAwake,
  output logic       timerDone,
  output logic       awakeHeld
);

  localparam int TAIL_CYC = LONG_CYC - SHORT_CYC;
  localparam int MAX_AB   = (PULSE_CYC > SHORT_CYC) ? PULSE_CYC : SHORT_CYC;
  localparam int MAX_CYC  = (MAX_AB > TAIL_CYC) ? MAX_AB : TAIL_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LD  = CNT_W'(TAIL_CYC - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (strobe.loadPulse) begin
      remain <= PULSE_LD;
    end else if (strobe.loadShort) begin
      remain <= SHORT_LD;
    end else if (strobe.loadLong) begin
      remain <= TAIL_LD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      awakeHeld <= 1'b0;
    end else if (strobe.captureAwake) begin
      awakeHeld <= panelAwake;
    end
  end

  assign timerDone = (remain == '0);

endmodule

// File: rtl/panel_rst_ctrl.sv
module panel_rst_ctrl
  import panel_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       timerDone,
  input  logic       awakeHeld,
  input  logic       cmdReq,
  input  logic       cmdIsWake,
  output seqStrobe_t strobe,
  output logic       panelResetN,
  output logic       busy,
  output logic       cmdGrant
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (startReq) begin
      nextState           = ST_ASSERT;
      strobe.loadPulse    = 1'b1;
      strobe.captureAwake = 1'b1;
    end else begin
      unique case (state)
        ST_ASSERT: begin
          if (timerDone) begin
            nextState        = ST_WAIT_SHORT;
            strobe.loadShort = 1'b1;
          end
        end
        ST_WAIT_SHORT: begin
          if (timerDone) begin
            if (awakeHeld) begin
              nextState       = ST_WAIT_LONG;
              strobe.loadLong = 1'b1;
            end else begin
              nextState = ST_READY;
            end
          end
        end
        ST_WAIT_LONG: begin
          if (timerDone) nextState = ST_READY;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      panelResetN <= 1'b1;
      busy        <= 1'b0;
    end else begin
      state       <= nextState;
      panelResetN <= (nextState != ST_ASSERT);
      busy        <= (nextState == ST_ASSERT) || (nextState == ST_WAIT_SHORT) ||
                     (nextState == ST_WAIT_LONG);
    end
  end

  always_comb begin
    cmdGrant = cmdReq && ((state == ST_READY) || ((state == ST_WAIT_LONG) && !cmdIsWake));
  end

endmodule

// File: rtl/panel_reset_seq.sv
module panel_reset_seq
  import panel_rst_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int PULSE_CYC = CLK_HZ / 100_000,
  parameter int SHORT_CYC = CLK_HZ / 200,
  parameter int LONG_CYC  = (CLK_HZ / 1000) * 120
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic panelAwake,
  input  logic cmdReq,
  input  logic cmdIsWake,
  output logic panelResetN,
  output logic cmdGrant,
  output logic busy
);

  seqStrobe_t strobe;
  logic       timerDone;
  logic       awakeHeld;

  panel_rst_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .timerDone  (timerDone),
    .awakeHeld  (awakeHeld),
    .cmdReq     (cmdReq),
    .cmdIsWake  (cmdIsWake),
    .strobe     (strobe),
    .panelResetN(panelResetN),
    .busy       (busy),
    .cmdGrant   (cmdGrant)
  );

  panel_rst_timer #(
    .PULSE_CYC(PULSE_CYC),
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) uTimer (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .panelAwake(panelAwake),
    .timerDone (timerDone),
    .awakeHeld (awakeHeld)
  );

endmodule

// File: rtl/panel_reset_seq_chk.sv
module panel_reset_seq_chk #(
  parameter int PULSE_CYC = 4,
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 25
) (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic panelAwake,
  input logic cmdReq,
  input logic cmdIsWake,
  input logic panelResetN,
  input logic cmdGrant,
  input logic busy
);

  int unsigned lowRun;
  int unsigned relRun;
  logic        released;
  logic        awakeAtStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun       <= 0;
      relRun       <= 0;
      released     <= 1'b0;
      awakeAtStart <= 1'b0;
    end else begin
      lowRun <= panelResetN ? 0 : ((lowRun < PULSE_CYC) ? lowRun + 1 : lowRun);
      relRun <= !panelResetN ? 0 : ((relRun < LONG_CYC) ? relRun + 1 : relRun);
      if (!panelResetN) released <= 1'b1;
      if (startReq) awakeAtStart <= panelAwake;
    end
  end

  // R2: pulse never shorter than the programmed width
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(panelResetN) |-> lowRun >= PULSE_CYC);

  // R2 / R8: start request takes effect at the next edge
  p_start_resp_r8: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (!panelResetN && busy));

  // R3 / R1: no grant before a completed reset and the general lockout
  p_short_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdGrant |-> (released && relRun >= SHORT_CYC));

  // R5: wake command after an awake start waits the long lockout
  p_wake_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdGrant && cmdIsWake && awakeAtStart) |-> relRun >= LONG_CYC);

  // R10: grant only on request
  p_grant_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdGrant |-> cmdReq);

  // R9: busy low after a sequence means reset released and general lockout over
  p_busy_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && released) |-> (panelResetN && relRun >= SHORT_CYC));

endmodule

bind panel_reset_seq panel_reset_seq_chk #(
  .PULSE_CYC(PULSE_CYC),
  .SHORT_CYC(SHORT_CYC),
  .LONG_CYC (LONG_CYC)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .panelAwake (panelAwake),
  .cmdReq     (cmdReq),
  .cmdIsWake  (cmdIsWake),
  .panelResetN(panelResetN),
  .cmdGrant   (cmdGrant),
  .busy       (busy)
);

// File: tb/tb_panel_reset_seq.sv
`timescale 1ns/1ps
module tb_panel_reset_seq;

  localparam int P     = 4;
  localparam int S     = 10;
  localparam int L     = 25;
  localparam int TOTAL = P + L + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic panelAwake = 1'b0;
  logic cmdReq = 1'b0;
  logic cmdIsWake = 1'b0;
  logic panelResetN, cmdGrant, busy;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    int    at;
    bit    rn;
    bit    bz;
    bit    gr;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  panel_reset_seq #(
    .PULSE_CYC(P),
    .SHORT_CYC(S),
    .LONG_CYC (L)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .panelAwake (panelAwake),
    .cmdReq     (cmdReq),
    .cmdIsWake  (cmdIsWake),
    .panelResetN(panelResetN),
    .cmdGrant   (cmdGrant),
    .busy       (busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input bit rn, input bit bz, input bit gr, input string tag);
    nChecks++;
    if (panelResetN !== rn || busy !== bz || cmdGrant !== gr) begin
      nFails++;
      $display("FAIL %s cyc=%0d actual rstN/busy/grant=%b%b%b expected=%b%b%b",
               tag, cyc, panelResetN, busy, cmdGrant, rn, bz, gr);
    end
  endtask

  // monitor: pops expected items as their cycle arrives
  always @(negedge clk) begin
    if (rstN) begin
      while (expQ.size() > 0 && expQ[0].at <= cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.at < cyc) begin
          nChecks++;
          nFails++;
          $display("FAIL %s missed sample actual cyc=%0d expected cyc=%0d", it.tag, cyc, it.at);
        end else begin
          compare(it.rn, it.bz, it.gr, it.tag);
        end
      end
    end
  end

  // expected trace from the requirement timings, cycle 0 = start edge
  task automatic pushSeq(input int c0, input bit awake, input bit wake, input bit req,
                         input int n, input string tag);
    int gate;
    int busyEnd;
    gate    = (wake && awake) ? P + L : P + S;
    busyEnd = awake ? P + L : P + S;
    for (int k = 0; k < n; k++) begin
      expItem_t it;
      it.at = c0 + k;
      it.rn = (k >= P);
      it.bz = (k < busyEnd);
      it.gr = req && (k >= gate);
      if (k < P)          it.tag = {"R2 ", tag};
      else if (k < P + S) it.tag = {"R3 ", tag};
      else                it.tag = {"R9 ", tag};
      expQ.push_back(it);
    end
  endtask

  task automatic runSeq(input bit awake, input bit wake, input bit req, input bit flip,
                        input string tag);
    int c0;
    @(negedge clk);
    cmdIsWake = wake;
    cmdReq    = req;
    c0        = cyc + 1;
    pushSeq(c0, awake, wake, req, TOTAL, tag);
    startReq   = 1'b1;
    panelAwake = awake;
    @(negedge clk);
    startReq = 1'b0;
    if (flip) panelAwake = !awake;
    repeat (TOTAL) @(negedge clk);
  endtask

  task automatic runRestart();
    int c0;
    int c1;
    @(negedge clk);
    cmdIsWake = 1'b1;
    cmdReq    = 1'b1;
    c0        = cyc + 1;
    pushSeq(c0, 1'b1, 1'b1, 1'b1, P + 2, "R8 first");
    startReq   = 1'b1;
    panelAwake = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (P + 1) @(negedge clk);
    c1 = cyc + 1;
    pushSeq(c1, 1'b0, 1'b1, 1'b1, TOTAL, "R8 restart");
    startReq   = 1'b1;
    panelAwake = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    repeat (TOTAL) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN   = 1'b1;
    cmdReq = 1'b1;
    @(negedge clk);
    compare(1'b1, 1'b0, 1'b0, "R1 idle after reset");
    cmdIsWake = 1'b1;
    @(negedge clk);
    compare(1'b1, 1'b0, 1'b0, "R1 idle wake req");

    runSeq(1'b0, 1'b1, 1'b1, 1'b0, "R6 asleep wake");
    runSeq(1'b1, 1'b1, 1'b1, 1'b0, "R5 awake wake");
    runSeq(1'b1, 1'b0, 1'b1, 1'b0, "R4 awake other");
    runSeq(1'b0, 1'b0, 1'b1, 1'b0, "R4 asleep other");
    runSeq(1'b1, 1'b1, 1'b1, 1'b1, "R7 awake flipped");
    runSeq(1'b0, 1'b1, 1'b1, 1'b1, "R7 asleep flipped");
    runSeq(1'b1, 1'b0, 1'b0, 1'b0, "R10 no request");
    runRestart();

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL queue not drained actual=%0d expected=0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule